// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block performs a full hardware context switch between two tasks whose saved state lives in per-task state areas in memory. A caller presents one switch request naming a kind (call, jump, gate-delivered interrupt, or return-from-nested) and a target selector. The block reads and validates the target descriptor. It updates the busy marks of the outgoing and incoming descriptors as the kind requires, stores the live register snapshot into the outgoing state area, and writes the back-link when the switch nests. It then points the task register at the new task and loads the incoming snapshot into the register file.

Memory is reached one word at a time through a valid/ready port. The block raises `mem_valid` and holds address, write enable and write data unchanged until `mem_ready` is seen high at a clock edge. The memory may stall for any number of cycles. The register file is reached through an indexed snapshot port: it reads combinationally and writes on a strobe. The request interface is also valid/ready. `req_ready` is high only while the block is idle. A requester must keep `req_valid` and the request fields stable until it sees them accepted. Once accepted, the block stays busy until the final snapshot word is loaded or a fault is reported.

Top module: `tsw_seq`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the block is idle and is low throughout a switch. Kind encoding: 0 call, 1 jump, 2 interrupt through a gate, 3 nested return.
- R2: If `long_mode` is high when a request is taken, the block reports fault code 1 on the following cycle. It performs no memory access and leaves `tr_sel` unchanged.
- R3: For call and jump, a requester privilege `req_epl` numerically greater than the descriptor privilege faults with code 2, and no memory word is written. Interrupt and return skip this test.
- R4: The descriptor of selector s sits at word address 2*(s>>3): word 0 holds the state-area base, and word 1 holds limit in bits 15:0, privilege in bits 17:16, present in bit 18 and busy in bit 19. A descriptor that is not present faults with code 3. A limit below 0x67 faults with code 4. The tests are taken in the order privilege, present, limit, busy.
- R5: Call, jump and interrupt require a clear target busy bit. Return requires it set. A mismatch faults with code 5, so a busy task cannot be re-entered.
- R6: For jump and return, the outgoing descriptor's word 1 is rewritten with bit 19 cleared. For call and interrupt it is not written.
- R7: Before anything is loaded, snapshot words 0..17 are stored at outgoing base+1+i. For a return, bit 14 (nested flag) of word 14 (flags) is stored cleared. All other words are stored unchanged.
- R8: For call and interrupt only, the outgoing selector is written to word 0 of the incoming state area.
- R9: For call, jump and interrupt, the incoming descriptor's word 1 is rewritten with bit 19 set. For a return it is not written.
- R10: The register file receives incoming base+1+i at index i. Flags bit 14 is forced to 1 for call and interrupt and is kept as stored for jump and return.
- R11: On success `tr_sel` takes the target selector and `done` pulses for one cycle. A fault pulses `fault_valid` for one cycle, leaves `tr_sel` unchanged, and never coincides with `done`.
- R12: A return takes its target selector from word 0 of the current task's state area.
- R13: While `mem_valid` is high and `mem_ready` is low, the address and write enable stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| long_mode | input | 1 | Switching forbidden; every request faults |
| req_valid | input | 1 | Switch request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_kind | input | 2 | Switch kind |
| req_sel | input | SW | Target selector (ignored for return) |
| req_epl | input | 2 | Requester privilege |
| done | output | 1 | Switch finished |
| fault_valid | output | 1 | Switch aborted |
| fault_code | output | 3 | Reason for abort |
| tr_sel | output | SW | Current task selector |
| mem_valid | output | 1 | Memory access pending |
| mem_ready | input | 1 | Memory accepts access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with ready |
| ctx_idx | output | IW | Snapshot word index |
| ctx_rdata | input | DW | Live snapshot word at ctx_idx |
| ctx_we | output | 1 | Snapshot word write strobe |
| ctx_wdata | output | DW | Snapshot word to load |

## Verification
Two functions share a cycle during the load phase. The completion of a memory read and the register-file write it feeds both happen on the same clock edge. The nested-flag edit on word 14 is applied combinationally in that same cycle. The memory model inserts stalls of zero to two cycles between accesses. These stalls move every handshake, including the one carrying the flags word, against a different edge than its neighbours. The scoreboard compares each memory write in order as it happens. After every switch the bench also compares the whole register file, so a load that fires on a stalled cycle or a flag edit applied to the wrong word shows as a mismatch.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [1:0] {
    K_CALL = 2'd0,
    K_JMP  = 2'd1,
    K_INT  = 2'd2,
    K_IRET = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    F_NONE   = 3'd0,
    F_LONG   = 3'd1,
    F_PRIV   = 3'd2,
    F_ABSENT = 3'd3,
    F_SHORT  = 3'd4,
    F_BUSY   = 3'd5
  } fault_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LINK, S_D0, S_D1, S_CHK, S_ORD, S_OWR,
    S_SAVE, S_LNKW, S_NBUSY, S_LOAD
  } state_e;

  localparam int DPL_LO   = 16;
  localparam int PRES_BIT = 18;
  localparam int BUSY_BIT = 19;
endpackage

// File: rtl/tsw_check.sv
module tsw_check
  import tsw_pkg::*;
#(
  parameter int MIN_LIMIT = 'h67
) (
  input  kind_e                 kind,
  input  logic [1:0]            epl,
  input  logic [BUSY_BIT:0]     attr,
  output fault_e                code
);
  logic [1:0] dpl;
  logic       explicit_sw;

  assign dpl         = attr[DPL_LO+1:DPL_LO];
  assign explicit_sw = (kind == K_CALL) || (kind == K_JMP);

  always_comb begin
    code = F_NONE;
    if (explicit_sw && (epl > dpl))
      code = F_PRIV;
    else if (!attr[PRES_BIT])
      code = F_ABSENT;
    else if (attr[15:0] < 16'(MIN_LIMIT))
      code = F_SHORT;
    else if ((kind == K_IRET) != attr[BUSY_BIT])
      code = F_BUSY;
  end
endmodule

// File: rtl/tsw_ntfix.sv
module tsw_ntfix #(
  parameter int DW     = 32,
  parameter int NT_BIT = 14
) (
  input  logic [DW-1:0] din,
  input  logic          hit,
  input  logic          clr,
  input  logic          set,
  output logic [DW-1:0] dout
);
  always_comb begin
    dout = din;
    if (hit && clr) dout[NT_BIT] = 1'b0;
    if (hit && set) dout[NT_BIT] = 1'b1;
  end
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 16,
  parameter int SW         = 16,
  parameter int CTX_WORDS  = 18,
  parameter int FLAGS_IDX  = 14,
  parameter int NT_BIT     = 14,
  parameter int MIN_LIMIT  = 'h67,
  parameter int GDT_BASE   = 0,
  parameter int RESET_TR   = 8,
  parameter int RESET_BASE = 64,
  localparam int IW        = $clog2(CTX_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          long_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [SW-1:0] req_sel,
  input  logic [1:0]    req_epl,
  output logic          done,
  output logic          fault_valid,
  output logic [2:0]    fault_code,
  output logic [SW-1:0] tr_sel,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [IW-1:0] ctx_idx,
  input  logic [DW-1:0] ctx_rdata,
  output logic          ctx_we,
  output logic [DW-1:0] ctx_wdata
);
  localparam logic [IW-1:0] LAST_IDX  = IW'(CTX_WORDS - 1);
  localparam logic [IW-1:0] FLAGS_POS = IW'(FLAGS_IDX);

  state_e        st;
  kind_e         kq, req_k;
  logic [1:0]    eplq;
  logic [SW-1:0] tgt;
  logic [AW-1:0] nbase, cbase;
  logic [DW-1:0] nattr, oattr;
  logic [IW-1:0] idx;
  fault_e        chk_code;
  logic          hs, last, nests, on_flags;
  logic [DW-1:0] save_word, load_word;

  assign req_k    = kind_e'(req_kind);
  assign req_ready = (st == S_IDLE);
  assign hs       = mem_valid && mem_ready;
  assign last     = (idx == LAST_IDX);
  assign nests    = (kq == K_CALL) || (kq == K_INT);
  assign on_flags = (idx == FLAGS_POS);
  assign ctx_idx  = idx;

  function automatic logic [AW-1:0] desc_at(input logic [SW-1:0] s);
    return AW'(GDT_BASE) + AW'({s[SW-1:3], 1'b0});
  endfunction

  tsw_check #(.MIN_LIMIT(MIN_LIMIT)) u_check (
    .kind (kq),
    .epl  (eplq),
    .attr (nattr[BUSY_BIT:0]),
    .code (chk_code)
  );

  tsw_ntfix #(.DW(DW), .NT_BIT(NT_BIT)) u_fix_out (
    .din (ctx_rdata), .hit (on_flags), .clr (kq == K_IRET), .set (1'b0),
    .dout(save_word)
  );

  tsw_ntfix #(.DW(DW), .NT_BIT(NT_BIT)) u_fix_in (
    .din (mem_rdata), .hit (on_flags), .clr (1'b0), .set (nests),
    .dout(load_word)
  );

  always_comb begin
    mem_valid = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_LINK:  mem_addr = cbase;
      S_D0:    mem_addr = desc_at(tgt);
      S_D1:    mem_addr = desc_at(tgt) + AW'(1);
      S_ORD:   mem_addr = desc_at(tr_sel) + AW'(1);
      S_OWR: begin
        mem_addr  = desc_at(tr_sel) + AW'(1);
        mem_we    = 1'b1;
        mem_wdata = oattr & ~(DW'(1) << BUSY_BIT);
      end
      S_SAVE: begin
        mem_addr  = cbase + AW'(1) + AW'(idx);
        mem_we    = 1'b1;
        mem_wdata = save_word;
      end
      S_LNKW: begin
        mem_addr  = nbase;
        mem_we    = 1'b1;
        mem_wdata = DW'(tr_sel);
      end
      S_NBUSY: begin
        mem_addr  = desc_at(tgt) + AW'(1);
        mem_we    = 1'b1;
        mem_wdata = nattr | (DW'(1) << BUSY_BIT);
      end
      S_LOAD:  mem_addr = nbase + AW'(1) + AW'(idx);
      default: mem_valid = 1'b0;
    endcase
  end

  assign ctx_we    = (st == S_LOAD) && mem_ready;
  assign ctx_wdata = load_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      kq          <= K_CALL;
      eplq        <= '0;
      tgt         <= '0;
      nbase       <= '0;
      nattr       <= '0;
      oattr       <= '0;
      idx         <= '0;
      cbase       <= AW'(RESET_BASE);
      tr_sel      <= SW'(RESET_TR);
      done        <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= F_NONE;
    end else begin
      done        <= 1'b0;
      fault_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          kq   <= req_k;
          eplq <= req_epl;
          tgt  <= req_sel;
          if (long_mode) begin
            fault_valid <= 1'b1;
            fault_code  <= F_LONG;
          end else begin
            st <= (req_k == K_IRET) ? S_LINK : S_D0;
          end
        end
        S_LINK: if (hs) begin
          tgt <= mem_rdata[SW-1:0];
          st  <= S_D0;
        end
        S_D0: if (hs) begin
          nbase <= mem_rdata[AW-1:0];
          st    <= S_D1;
        end
        S_D1: if (hs) begin
          nattr <= mem_rdata;
          st    <= S_CHK;
        end
        S_CHK: begin
          idx <= '0;
          if (chk_code != F_NONE) begin
            fault_valid <= 1'b1;
            fault_code  <= chk_code;
            st          <= S_IDLE;
          end else if (kq == K_JMP || kq == K_IRET) begin
            st <= S_ORD;
          end else begin
            st <= S_SAVE;
          end
        end
        S_ORD: if (hs) begin
          oattr <= mem_rdata;
          st    <= S_OWR;
        end
        S_OWR: if (hs) st <= S_SAVE;
        S_SAVE: if (hs) begin
          if (last) begin
            idx <= '0;
            if (nests) begin
              st <= S_LNKW;
            end else if (kq == K_JMP) begin
              st <= S_NBUSY;
            end else begin
              tr_sel <= tgt;
              cbase  <= nbase;
              st     <= S_LOAD;
            end
          end else begin
            idx <= idx + IW'(1);
          end
        end
        S_LNKW: if (hs) st <= S_NBUSY;
        S_NBUSY: if (hs) begin
          tr_sel <= tgt;
          cbase  <= nbase;
          st     <= S_LOAD;
        end
        S_LOAD: if (hs) begin
          if (last) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsw_seq_chk.sv
module tsw_seq_chk #(
  parameter int AW = 16,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          long_mode,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          fault_valid,
  input logic [2:0]    fault_code,
  input logic [SW-1:0] tr_sel,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          ctx_we
);
  a_r1_busy_while_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  a_r2_long_mode_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && long_mode) |=> (fault_valid && fault_code == 3'd1));

  a_r11_done_fault_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault_valid));

  a_r11_fault_keeps_tr: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $stable(tr_sel));

  a_r10_load_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we |-> (mem_valid && mem_ready && !mem_we));

  a_r13_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind tsw_seq tsw_seq_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .long_mode  (long_mode),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .fault_valid(fault_valid),
  .fault_code (fault_code),
  .tr_sel     (tr_sel),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .ctx_we     (ctx_we)
);

// File: tb/tb_tsw_seq.sv
`timescale 1ns/1ps
module tb_tsw_seq;
  localparam int KC = 0, KJ = 1, KI = 2, KR = 3;
  localparam logic [31:0] BUSY = 32'h0008_0000;
  localparam int NW = 18;

  logic        clk = 0, rst_n = 0;
  logic        long_mode = 0, req_valid = 0, req_ready;
  logic [1:0]  req_kind = 0, req_epl = 0;
  logic [15:0] req_sel = 0;
  logic        done, fault_valid;
  logic [2:0]  fault_code;
  logic [15:0] tr_sel;
  logic        mem_valid, mem_ready, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [4:0]  ctx_idx;
  logic [31:0] ctx_rdata, ctx_wdata;
  logic        ctx_we;

  logic [31:0] mem [0:255];
  logic [31:0] ctx [0:NW-1];
  logic [1:0]  stall;
  logic [3:0]  pat;
  int nchecks = 0, nfail = 0, cyc = 0;
  logic [15:0] exp_tr;
  logic        pend;
  logic [15:0] pend_addr;

  typedef struct packed { logic [7:0] tag; logic [15:0] a; logic [31:0] d; } wr_t;
  wr_t q[$];

  always #10 clk = ~clk;

  tsw_seq dut (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_sel(req_sel), .req_epl(req_epl), .done(done),
    .fault_valid(fault_valid), .fault_code(fault_code), .tr_sel(tr_sel),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ctx_idx(ctx_idx), .ctx_rdata(ctx_rdata), .ctx_we(ctx_we),
    .ctx_wdata(ctx_wdata)
  );

  assign mem_ready = mem_valid && (stall == 2'd0);
  assign mem_rdata = mem[mem_addr[7:0]];
  assign ctx_rdata = ctx[ctx_idx];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int dw1(input logic [15:0] s);
    return int'(s >> 3) * 2 + 1;
  endfunction

  function automatic int base_of(input logic [15:0] s);
    return int'(mem[int'(s >> 3) * 2][7:0]);
  endfunction

  // memory stall pattern, advanced at the edge like a register
  always @(posedge clk) begin
    if (!rst_n) begin
      stall <= 0; pat <= 0;
    end else if (mem_valid && mem_ready) begin
      pat   <= pat + 1;
      stall <= (pat % 3 == 0) ? 2'd2 : ((pat % 3 == 1) ? 2'd0 : 2'd1);
    end else if (stall != 0) begin
      stall <= stall - 1;
    end
  end

  // monitor: scoreboard of memory writes, register-file writes, stall hold
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk("R13 request held during stall", {15'd0, mem_valid, mem_addr},
            {15'd0, 1'b1, pend_addr});
      end
      pend      = mem_valid && !mem_ready;
      pend_addr = mem_addr;
      if (mem_valid && mem_ready && mem_we) begin
        if (q.size() == 0) begin
          nchecks++; nfail++;
          $display("FAIL R3 unexpected write actual=%h@%h expected=none", mem_wdata, mem_addr);
        end else begin
          wr_t w;
          w = q.pop_front();
          chk($sformatf("R%0d write addr", w.tag), {16'd0, mem_addr}, {16'd0, w.a});
          chk($sformatf("R%0d write data @%0d", w.tag, w.a), mem_wdata, w.d);
        end
        mem[mem_addr[7:0]] = mem_wdata;
      end
      if (ctx_we) ctx[ctx_idx] = ctx_wdata;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end

  task automatic push(input int tag, input int a, input logic [31:0] d);
    wr_t w;
    w.tag = 8'(tag); w.a = 16'(a); w.d = d;
    q.push_back(w);
  endtask

  task automatic issue(input int kind, input logic [15:0] sel, input logic [1:0] epl);
    @(negedge clk);
    req_kind = 2'(kind); req_sel = sel; req_epl = epl; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_end();
    while (!(done || fault_valid)) @(negedge clk);
  endtask

  task automatic expect_fault(input int kind, input logic [15:0] sel,
                              input logic [1:0] epl, input int code, input string tag);
    issue(kind, sel, epl);
    wait_end();
    chk({tag, " fault pulse"}, {31'd0, fault_valid}, 32'd1);
    chk({tag, " fault code"}, {29'd0, fault_code}, 32'(code));
    chk("R11 no done with fault", {31'd0, done}, 32'd0);
    chk("R11 tr kept on fault", {16'd0, tr_sel}, {16'd0, exp_tr});
    chk({tag, " no pending writes"}, 32'(q.size()), 32'd0);
  endtask

  task automatic expect_switch(input int kind, input logic [15:0] sel, input logic [1:0] epl);
    int cb, nb;
    logic [15:0] tgt;
    logic [31:0] v;
    logic [31:0] ex [0:NW-1];
    cb  = base_of(exp_tr);
    tgt = (kind == KR) ? mem[cb][15:0] : sel;
    nb  = base_of(tgt);
    if (kind == KJ || kind == KR) push(6, dw1(exp_tr), mem[dw1(exp_tr)] & ~BUSY);
    for (int i = 0; i < NW; i++) begin
      v = ctx[i];
      if (kind == KR && i == 14) v[14] = 1'b0;
      push(7, cb + 1 + i, v);
    end
    if (kind == KC || kind == KI) push(8, nb, {16'd0, exp_tr});
    if (kind != KR) push(9, dw1(tgt), mem[dw1(tgt)] | BUSY);
    for (int i = 0; i < NW; i++) begin
      ex[i] = mem[nb + 1 + i];
      if ((kind == KC || kind == KI) && i == 14) ex[i][14] = 1'b1;
    end
    issue(kind, sel, epl);
    chk("R1 ready low while switching", {31'd0, req_ready}, 32'd0);
    wait_end();
    chk("R11 done pulse", {31'd0, done}, 32'd1);
    chk("R11 no fault", {31'd0, fault_valid}, 32'd0);
    chk("R7 all writes seen", 32'(q.size()), 32'd0);
    for (int i = 0; i < NW; i++)
      chk($sformatf("R10 ctx word %0d", i), ctx[i], ex[i]);
    chk((kind == KR) ? "R12 tr from link" : "R11 tr updated",
        {16'd0, tr_sel}, {16'd0, tgt});
    exp_tr = tgt;
    @(negedge clk);
    chk("R11 done single cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    mem[2] = 32'd64;  mem[3] = 32'h000C_0067;   // task at selector 8, busy
    mem[4] = 32'd96;  mem[5] = 32'h0004_0067;   // selector 16, available
    mem[6] = 32'd128; mem[7] = 32'h0000_0067;   // selector 24, absent
    mem[8] = 32'd160; mem[9] = 32'h0004_0066;   // selector 32, too short
    for (int i = 0; i < NW; i++) begin
      ctx[i]        = 32'hA000_0000 + i;
      mem[65 + i]   = 32'hC000_0000 + i;
      mem[97 + i]   = 32'hB000_0000 + i;
    end
    ctx[14]  = 32'h0000_4202;
    mem[111] = 32'h0000_0002;
    exp_tr = 16'd8;
    pend = 0; pend_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R11 reset task register", {16'd0, tr_sel}, 32'd8);
    chk("R11 reset outputs quiet", {30'd0, done, fault_valid}, 32'd0);

    long_mode = 1;
    expect_fault(KC, 16'd16, 2'd0, 1, "R2");
    long_mode = 0;
    expect_fault(KC, 16'd16, 2'd3, 2, "R3");
    expect_fault(KJ, 16'd24, 2'd0, 3, "R4");
    expect_fault(KJ, 16'd32, 2'd0, 4, "R4");

    expect_switch(KC, 16'd16, 2'd0);     // R8 link, R9 busy set, R10 NT forced
    expect_fault(KC, 16'd8, 2'd0, 5, "R5");
    expect_switch(KR, 16'd0, 2'd3);      // R12, R6 clear, R7 NT cleared
    expect_switch(KJ, 16'd16, 2'd0);     // R6 clear old, R10 NT kept
    expect_switch(KI, 16'd8, 2'd3);      // interrupt ignores privilege
    expect_switch(KR, 16'd0, 2'd0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule